// File: doc/BRIEF.md
# Chained Packed-Decimal Byte Adder

This block adds two long decimal numbers held as packed BCD, two digits to a byte, by taking one byte from each operand per step. A step sums the source byte, the destination byte and the carry left by the previous step, applies decimal correction to each digit, and returns the corrected byte. The flags carry the decimal carry and a running zero indication from one step to the next. After the final byte of a chain, the flags show whether the whole number overflowed and whether every result digit is zero.

A chain begins with a one-cycle `start` pulse that sets the number of byte pairs to process. The flags are then initialised, with the extend and carry flags cleared and the zero flag set. The operand stream delivers byte pairs least significant first, using a valid/ready handshake. Every accepted pair produces one registered sum byte flagged by `sum_valid`. The chain finishes with a one-cycle `done` pulse. Producing operand addresses is the job of the surrounding logic, which would normally walk downward from the highest address.

Top module: `bcd_chain_adder`

## Requirements
- R1: After reset the block is idle: `in_ready`, `sum_valid` and `done` are 0 and `ccr_flags` is 5'b00100. The `ccr_flags` bits are bit4 X (extend), bit3 N, bit2 Z, bit1 V and bit0 C.
- R2: When `start` is seen while idle with a nonzero `byte_count`, the flags are loaded with X=0, C=0 and Z=1 on that clock edge, and `in_ready` is 1 from the next cycle until the chain ends.
- R3: On an accepted pair (`in_valid` and `in_ready`), `sum_byte` becomes the packed BCD value of (src + dst + X) mod 100 on the next cycle, with `sum_valid` high for exactly that cycle. Digits are bits 7:4 (tens) and 3:0 (units).
- R4: After each step, C and X are both 1 when the decimal sum reaches 100 or more, and both 0 otherwise.
- R5: After each step, Z is 0 if the result byte is nonzero and keeps its previous value if the result byte is zero. Only a new chain sets Z.
- R6: After each step, N equals bit 7 of the result byte and V is 0.
- R7: `done` pulses for one cycle, together with the `sum_valid` of the `byte_count`-th pair, and `in_ready` falls at the same time. If `byte_count` is 0, `done` pulses on the cycle after `start` and no pair is accepted.
- R8: Pairs are consumed in arrival order, least significant first, and the X left by one step is the carry-in of the next step.
- R9: `in_valid` while idle has no effect: no `sum_valid` occurs and `ccr_flags` stays unchanged.
- R10: `start` while a chain is running is ignored: the flags, the remaining count and the chain length are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a chain when idle |
| byte_count | input | CNT_W | Number of byte pairs in the chain |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block accepts an operand pair |
| src_byte | input | 8 | Source operand byte, packed BCD |
| dst_byte | input | 8 | Destination operand byte, packed BCD |
| sum_valid | output | 1 | Sum byte is valid this cycle |
| sum_byte | output | 8 | Corrected packed BCD sum byte |
| ccr_flags | output | 5 | Flags {X, N, Z, V, C} |
| done | output | 1 | Single-cycle end-of-chain pulse |

## Verification
The assertions assume that every operand byte accepted by the handshake holds two valid decimal digits (0 to 9). One property checks that assumption directly, and the property that every result digit is decimal depends on it. The stimulus only builds operand bytes by encoding integers from 0 to 99, so the assumption always holds. The bench compares every result against an integer model of the decimal chain, and this includes every carry-in case.

// File: rtl/bcd_chain_pkg.sv
// Shared constants, flag layout and helpers for the chained decimal adder.
// Assumes a fixed operand size of one byte holding two BCD digits.
package bcd_chain_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGITS  = 2;
    localparam int BYTE_W  = DIGIT_W * DIGITS;

    // Flag word, most significant field first: X N Z V C
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    localparam ccr_t CCR_RESET = '{x: 1'b0, n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};

    // True when every nibble of a byte is a decimal digit
    function automatic logic is_decimal(input logic [BYTE_W-1:0] b);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (b[i*DIGIT_W +: DIGIT_W] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/bcd_digit_add.sv
// One decimal digit adder: a + b + cin with decimal correction.
// Assumes a and b are in 0..9; the raw sum then never exceeds 19.
module bcd_digit_add
    import bcd_chain_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] s,
    output logic               cout
);
    localparam int RAW_W = DIGIT_W + 1;

    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] fixed;

    // Binary sum, then add six when the digit passes nine
    always_comb begin
        raw   = RAW_W'(a) + RAW_W'(b) + RAW_W'(cin);
        cout  = (raw > RAW_W'(9));
        fixed = cout ? raw + RAW_W'(6) : raw;
        s     = fixed[DIGIT_W-1:0];
    end
endmodule

// File: rtl/bcd_byte_add.sv
// Ripple of digit adders forming one packed BCD byte adder.
// Assumes every input nibble is decimal.
module bcd_byte_add
    import bcd_chain_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    output logic [BYTE_W-1:0] s,
    output logic              cout
);
    logic [DIGITS:0] carry;

    assign carry[0] = cin;
    assign cout     = carry[DIGITS];

    genvar g;
    generate
        for (g = 0; g < DIGITS; g++) begin : g_digit
            bcd_digit_add u_digit (
                .a    (a[g*DIGIT_W +: DIGIT_W]),
                .b    (b[g*DIGIT_W +: DIGIT_W]),
                .cin  (carry[g]),
                .s    (s[g*DIGIT_W +: DIGIT_W]),
                .cout (carry[g+1])
            );
        end
    endgenerate
endmodule

// File: rtl/bcd_chain_ctrl.sv
// Chain sequencer: accepts start when idle, counts accepted byte pairs
// and raises a one-cycle done pulse at the end of the chain.
// Assumes start is a pulse; start while running is ignored.
module bcd_chain_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             in_valid,
    output logic             busy,
    output logic             load,
    output logic             take,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remaining;
    logic             last_take;

    // Handshake and chain-start decode
    always_comb begin
        load      = start && !busy;
        take      = busy && in_valid;
        last_take = take && (remaining == ONE);
    end

    // Run state, remaining count and end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            remaining <= '0;
            done      <= 1'b0;
        end else begin
            done <= (load && (byte_count == '0)) || last_take;
            if (load) begin
                busy      <= (byte_count != '0);
                remaining <= byte_count;
            end else if (take) begin
                remaining <= remaining - ONE;
                if (last_take) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bcd_chain_adder.sv
// Top of the chained packed BCD adder: one byte pair per accepted
// handshake, registered sum, and X/C/Z flags carried across the chain.
// Assumes operand bytes hold decimal digits and arrive least significant first.
module bcd_chain_adder
    import bcd_chain_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        src_byte,
    input  logic [7:0]        dst_byte,
    output logic              sum_valid,
    output logic [7:0]        sum_byte,
    output logic [4:0]        ccr_flags,
    output logic              done
);
    logic              busy;
    logic              load;
    logic              take;
    logic [BYTE_W-1:0] step_sum;
    logic              step_carry;
    ccr_t              ccr_q;

    bcd_chain_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_count (byte_count),
        .in_valid   (in_valid),
        .busy       (busy),
        .load       (load),
        .take       (take),
        .done       (done)
    );

    bcd_byte_add u_add (
        .a    (src_byte),
        .b    (dst_byte),
        .cin  (ccr_q.x),
        .s    (step_sum),
        .cout (step_carry)
    );

    assign in_ready  = busy;
    assign ccr_flags = ccr_q;

    // Result register and flag update per accepted pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_valid <= 1'b0;
            sum_byte  <= '0;
            ccr_q     <= CCR_RESET;
        end else begin
            sum_valid <= take;
            if (load) begin
                ccr_q.x <= 1'b0;
                ccr_q.c <= 1'b0;
                ccr_q.z <= 1'b1;
            end else if (take) begin
                sum_byte <= step_sum;
                ccr_q.x  <= step_carry;
                ccr_q.c  <= step_carry;
                ccr_q.n  <= step_sum[BYTE_W-1];
                ccr_q.v  <= 1'b0;
                if (step_sum != '0) ccr_q.z <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bcd_chain_adder_checker.sv
// Temporal checks for the chained BCD adder, bound to its top.
// Assumes operands at the handshake are decimal (checked below).
module bcd_chain_adder_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] src_byte,
    input logic [7:0] dst_byte,
    input logic       sum_valid,
    input logic [7:0] sum_byte,
    input logic [4:0] ccr_flags,
    input logic       done
);
    import bcd_chain_pkg::*;

    // Input assumption that the decimal result relies on (R3)
    assert_decimal_operands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (is_decimal(src_byte) && is_decimal(dst_byte)));

    assert_decimal_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> is_decimal(sum_byte));

    assert_carry_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (ccr_flags[4] == ccr_flags[0]));

    assert_zero_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && sum_byte != 8'h00) |-> !ccr_flags[2]);

    assert_zero_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccr_flags[2] && !start) |=> !ccr_flags[2]);

    assert_sign_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> (ccr_flags[3] == sum_byte[7] && !ccr_flags[1]));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_no_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !start) |=> (!sum_valid && $stable(ccr_flags)));
endmodule

bind bcd_chain_adder bcd_chain_adder_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .src_byte  (src_byte),
    .dst_byte  (dst_byte),
    .sum_valid (sum_valid),
    .sum_byte  (sum_byte),
    .ccr_flags (ccr_flags),
    .done      (done)
);

// File: tb/bcd_chain_adder_bench.sv
`timescale 1ns/1ps
module bcd_chain_adder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_count = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] src_byte = '0;
    logic [7:0] dst_byte = '0;
    logic       sum_valid;
    logic [7:0] sum_byte;
    logic [4:0] ccr_flags;
    logic       done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit mx;
    bit mz;

    always #2 clk = ~clk;

    bcd_chain_adder u_bcd_chain_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .in_valid(in_valid), .in_ready(in_ready), .src_byte(src_byte),
        .dst_byte(dst_byte), .sum_valid(sum_valid), .sum_byte(sum_byte),
        .ccr_flags(ccr_flags), .done(done)
    );

    function automatic logic [7:0] enc(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Begin a chain; checks R2 when count is nonzero
    task automatic begin_chain(input int cnt);
        start = 1'b1;
        byte_count = 8'(cnt);
        @(negedge clk);
        start = 1'b0;
        mx = 1'b0;
        mz = 1'b1;
        if (cnt != 0) begin
            chk(ccr_flags[4] == 1'b0 && ccr_flags[0] == 1'b0 && ccr_flags[2] == 1'b1,
                "R2 flags at start", ccr_flags, 5'b00100);
            chk(in_ready == 1'b1, "R2 ready", in_ready, 1);
        end
    endtask

    // One byte pair; checks R3 R4 R5 R6 R8 and R7 for the last pair
    task automatic step(input int a, input int b, input bit last);
        int total;
        logic [7:0] exp_sum;
        logic [4:0] exp_f;
        src_byte = enc(a);
        dst_byte = enc(b);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        total = a + b + int'(mx);
        exp_sum = enc(total % 100);
        mx = (total >= 100);
        if (exp_sum != 8'h00) mz = 1'b0;
        exp_f = {mx, exp_sum[7], mz, 1'b0, mx};
        chk(sum_valid == 1'b1 && sum_byte == exp_sum, "R3 R8 sum byte", sum_byte, exp_sum);
        chk(ccr_flags == exp_f, "R4 R5 R6 flags", ccr_flags, exp_f);
        chk(done == last && in_ready == !last, "R7 done/ready", {done, in_ready}, {last, !last});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_ready == 0 && sum_valid == 0 && done == 0, "R1 idle outputs",
            {in_ready, sum_valid, done}, 0);
        chk(ccr_flags == 5'b00100, "R1 flags", ccr_flags, 5'b00100);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: in_valid while idle is ignored
        src_byte = 8'h45; dst_byte = 8'h67; in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(sum_valid == 1'b0, "R9 no sum when idle", sum_valid, 0);
        chk(ccr_flags == 5'b00100, "R9 flags kept", ccr_flags, 5'b00100);

        // R7: zero-length chain
        begin_chain(0);
        chk(done == 1'b1 && in_ready == 1'b0, "R7 empty chain done", {done, in_ready}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);

        // Exhaustive single-byte chains, carry-in 0 (R3 R4 R5 R6)
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++) begin
                begin_chain(1);
                step(a, b, 1'b1);
            end

        // Exhaustive second byte with carry-in 1 (R8): 99+01 forces X
        for (int a = 0; a < 100; a++)
            for (int b = 0; b < 100; b++) begin
                begin_chain(2);
                step(99, 1, 1'b0);
                step(a, b, 1'b1);
            end

        // R5: all-zero multi-byte chain keeps Z
        begin_chain(4);
        for (int i = 0; i < 4; i++) step(0, 0, i == 3);
        chk(ccr_flags[2] == 1'b1, "R5 zero chain Z", ccr_flags[2], 1);

        // R5: nonzero low byte then zeros leaves Z clear
        begin_chain(3);
        step(1, 0, 1'b0);
        step(0, 0, 1'b0);
        step(0, 0, 1'b1);
        chk(ccr_flags[2] == 1'b0, "R5 sticky clear", ccr_flags[2], 0);

        // R8: carry ripple 99999999 + 00000001 = 1_00000000
        begin_chain(4);
        step(99, 1, 1'b0);
        step(99, 0, 1'b0);
        step(99, 0, 1'b0);
        step(99, 0, 1'b1);
        chk(ccr_flags[4] == 1'b1 && ccr_flags[2] == 1'b1, "R8 ripple carry out Z",
            ccr_flags, 5'b10101);

        // R10: start during a chain is ignored
        begin_chain(3);
        step(50, 50, 1'b0);
        start = 1'b1; byte_count = 8'd1;
        @(negedge clk);
        start = 1'b0;
        chk(ccr_flags[4] == 1'b1 && ccr_flags[2] == 1'b1 && in_ready == 1'b1,
            "R10 flags and run kept", {ccr_flags, in_ready}, {5'b10101, 1'b1});
        step(0, 0, 1'b0);
        step(12, 30, 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule